// File: doc/BRIEF.md
# Multi-View Pixel Store

This block holds one 26-bit entry per pixel: a 24-bit colour value in bits 23:0 and a 2-bit display mode in bits 25:24. The mode codes are 00 for an 8-bit index looked up in the colour map, 01 for 24-bit colour looked up in the map, and 11 for 24-bit direct colour that bypasses the map. A host bus reaches the same storage through three aliased windows that decode it differently.

The full window shows the mode and colour of one pixel per word. The colour window shows only the colour and protects the mode from writes. The index window packs the low bytes of four neighbouring pixels into one word. A separate scan-out read port feeds stored colour and mode to the display pipeline.

Neither port applies back-pressure. Every host request and every scan-out request is accepted in the cycle it is presented, so the block has no ready outputs. Each read answers exactly one cycle later with a valid strobe, and the consumer must take that answer in that cycle.

Top module: `pixel_aperture_mem`

## Requirements
- R1: The two host address bits above the PIX_AW-bit offset select the window: 00 is the index window, 01 is the colour window, 10 is the full window and 11 is unmapped. Every window reads and writes the same storage.
- R2: In the full window, word offset W is pixel W. A read returns bits 25:0 of the pixel with bits 31:26 as zero. Byte enables 0 to 2 write the three colour bytes. Byte enable 3 writes the mode from wdata bits 25:24. Write bits 31:26 are ignored.
- R3: In the colour window, word offset W is pixel W. A read returns the colour in bits 23:0 with bits 31:24 as zero. Byte enables 0 to 2 write the colour bytes. Byte lane 3 is ignored on writes, so the mode never changes through this window.
- R4: In the index window, word offset W covers pixels 4W to 4W+3. Byte lane k (wdata bits 8k+7:8k) maps to pixel 4W+k. A write changes only bits 7:0 of each enabled pixel, and a read returns the four index bytes.
- R5: In every window, a byte lane whose enable is 0 leaves the stored bits behind that lane unchanged.
- R6: A read of the unmapped window returns zero, and a write to it changes no pixel.
- R7: A host read (host_req=1, host_we=0) raises host_rvalid with its data in the next cycle. A write or an idle cycle leaves host_rvalid low in the next cycle.
- R8: A scan-out request raises scan_valid in the next cycle with the pixel's colour and mode. When a host write and a scan-out read hit the same pixel in the same cycle, the scan-out returns the contents from before the write and the write takes effect.
- R9: Reset clears host_rvalid and scan_valid but does not alter stored pixels.
- R10: In the index window, only the low PIX_AW-2 offset bits are decoded. Offsets that differ only in the higher bits alias to the same four pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, accepted every cycle |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | PIX_AW+2 | Window select (top 2 bits) and word offset |
| host_be | input | 4 | Byte-lane write enables |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read answer strobe, one cycle after the request |
| scan_en | input | 1 | Scan-out read request |
| scan_addr | input | PIX_AW | Scan-out pixel number |
| scan_valid | output | 1 | Scan-out answer strobe |
| scan_color | output | 24 | Colour of the requested pixel |
| scan_mode | output | 2 | Display mode of the requested pixel |

## Verification
The bench builds the block with PIX_AW=6, which gives 64 pixels. At this size a single pass of full-window writes can clear the whole store, and every later read compares against known contents. With 64 pixels the index window spans 16 words, so offsets 16 and up reach the aliasing of the undecoded high bits. A long run of random mixed requests across all four window codes, with scan-out reads overlapping host writes, hits same-pixel collisions and partial byte enables many times.

// File: rtl/pixap_pkg.sv
package pixap_pkg;
  localparam int LANES    = 4;
  localparam int PIXW     = 26;
  localparam int COLOR_W  = 24;

  typedef enum logic [1:0] {
    VIEW_INDEX = 2'b00,
    VIEW_COLOR = 2'b01,
    VIEW_FULL  = 2'b10,
    VIEW_NONE  = 2'b11
  } pixap_view_e;
endpackage

// File: rtl/pixap_decode.sv
module pixap_decode
  import pixap_pkg::*;
#(
  parameter int PIX_AW = 8
) (
  input  logic                               host_req,
  input  logic                               host_we,
  input  logic [1:0]                         view,
  input  logic [PIX_AW-1:0]                  word_off,
  input  logic [LANES-1:0]                   host_be,
  input  logic [31:0]                        host_wdata,
  output logic [LANES-1:0]                   wr_en,
  output logic [LANES-1:0][PIX_AW-1:0]       wr_pix,
  output logic [LANES-1:0][PIXW-1:0]         wr_mask,
  output logic [LANES-1:0][PIXW-1:0]         wr_data,
  output logic [LANES-1:0][PIX_AW-1:0]       rd_pix
);
  logic wr_go;
  assign wr_go = host_req & host_we;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      wr_en[l]   = 1'b0;
      wr_pix[l]  = word_off;
      wr_mask[l] = '0;
      wr_data[l] = '0;
      rd_pix[l]  = word_off;
    end
    case (pixap_view_e'(view))
      VIEW_INDEX: begin
        for (int k = 0; k < LANES; k++) begin
          wr_pix[k]  = {word_off[PIX_AW-3:0], k[1:0]};
          rd_pix[k]  = {word_off[PIX_AW-3:0], k[1:0]};
          wr_en[k]   = wr_go & host_be[k];
          wr_mask[k] = PIXW'(8'hFF);
          wr_data[k] = PIXW'(host_wdata[8*k +: 8]);
        end
      end
      VIEW_COLOR, VIEW_FULL: begin
        wr_en[0]   = wr_go;
        wr_mask[0] = {(view == VIEW_FULL && host_be[3]) ? 2'b11 : 2'b00,
                      {8{host_be[2]}}, {8{host_be[1]}}, {8{host_be[0]}}};
        wr_data[0] = host_wdata[PIXW-1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pixap_store.sv
module pixap_store
  import pixap_pkg::*;
#(
  parameter int PIX_AW = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [LANES-1:0]                   wr_en,
  input  logic [LANES-1:0][PIX_AW-1:0]       wr_pix,
  input  logic [LANES-1:0][PIXW-1:0]         wr_mask,
  input  logic [LANES-1:0][PIXW-1:0]         wr_data,
  input  logic                               rd_en,
  input  logic [LANES-1:0][PIX_AW-1:0]       rd_pix,
  input  logic                               scan_en,
  input  logic [PIX_AW-1:0]                  scan_addr,
  output logic [PIXW-1:0]                    host_word,
  output logic [LANES-1:1][7:0]              host_bytes,
  output logic                               rd_valid,
  output logic [PIXW-1:0]                    scan_word,
  output logic                               scan_valid
);
  localparam int NPIX = 1 << PIX_AW;

  logic [PIXW-1:0] mem [NPIX];

  // Lanes never share a pixel within one request, so order is irrelevant.
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_en[l])
        mem[wr_pix[l]] <= (mem[wr_pix[l]] & ~wr_mask[l]) | (wr_data[l] & wr_mask[l]);
    end
  end

  // Read data registers hold no reset: they are qualified by the strobes.
  always_ff @(posedge clk) begin
    if (rd_en) begin
      host_word <= mem[rd_pix[0]];
      for (int k = 1; k < LANES; k++)
        host_bytes[k] <= mem[rd_pix[k]][7:0];
    end
    if (scan_en)
      scan_word <= mem[scan_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      scan_valid <= 1'b0;
    end else begin
      rd_valid   <= rd_en;
      scan_valid <= scan_en;
    end
  end
endmodule

// File: rtl/pixap_format.sv
module pixap_format
  import pixap_pkg::*;
(
  input  logic [1:0]              view_q,
  input  logic [PIXW-1:0]         host_word,
  input  logic [LANES-1:1][7:0]   host_bytes,
  output logic [31:0]             host_rdata
);
  always_comb begin
    case (pixap_view_e'(view_q))
      VIEW_INDEX: host_rdata = {host_bytes[3], host_bytes[2], host_bytes[1], host_word[7:0]};
      VIEW_COLOR: host_rdata = {8'h00, host_word[COLOR_W-1:0]};
      VIEW_FULL:  host_rdata = {{(32-PIXW){1'b0}}, host_word};
      default:    host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pixel_aperture_mem.sv
module pixel_aperture_mem
  import pixap_pkg::*;
#(
  parameter int PIX_AW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_req,
  input  logic                 host_we,
  input  logic [PIX_AW+1:0]    host_addr,
  input  logic [3:0]           host_be,
  input  logic [31:0]          host_wdata,
  output logic [31:0]          host_rdata,
  output logic                 host_rvalid,
  input  logic                 scan_en,
  input  logic [PIX_AW-1:0]    scan_addr,
  output logic                 scan_valid,
  output logic [23:0]          scan_color,
  output logic [1:0]           scan_mode
);
  logic [1:0]                        view, view_q;
  logic [PIX_AW-1:0]                 word_off;
  logic                              rd_en;
  logic [LANES-1:0]                  wr_en;
  logic [LANES-1:0][PIX_AW-1:0]      wr_pix, rd_pix;
  logic [LANES-1:0][PIXW-1:0]        wr_mask, wr_data;
  logic [PIXW-1:0]                   host_word, scan_word;
  logic [LANES-1:1][7:0]             host_bytes;

  assign view     = host_addr[PIX_AW+1:PIX_AW];
  assign word_off = host_addr[PIX_AW-1:0];
  assign rd_en    = host_req & ~host_we;

  always_ff @(posedge clk) begin
    if (rd_en) view_q <= view;
  end

  pixap_decode #(.PIX_AW(PIX_AW)) u_dec (
    .host_req(host_req), .host_we(host_we), .view(view), .word_off(word_off),
    .host_be(host_be), .host_wdata(host_wdata), .wr_en(wr_en), .wr_pix(wr_pix),
    .wr_mask(wr_mask), .wr_data(wr_data), .rd_pix(rd_pix)
  );

  pixap_store #(.PIX_AW(PIX_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pix(wr_pix), .wr_mask(wr_mask),
    .wr_data(wr_data), .rd_en(rd_en), .rd_pix(rd_pix), .scan_en(scan_en),
    .scan_addr(scan_addr), .host_word(host_word), .host_bytes(host_bytes),
    .rd_valid(host_rvalid), .scan_word(scan_word), .scan_valid(scan_valid)
  );

  pixap_format u_fmt (
    .view_q(view_q), .host_word(host_word), .host_bytes(host_bytes),
    .host_rdata(host_rdata)
  );

  assign scan_color = scan_word[COLOR_W-1:0];
  assign scan_mode  = scan_word[PIXW-1:COLOR_W];
endmodule

// File: rtl/pixap_checker.sv
module pixap_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        host_req,
  input logic        host_we,
  input logic [1:0]  host_view,
  input logic [31:0] host_rdata,
  input logic        host_rvalid,
  input logic        scan_en,
  input logic        scan_valid
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we) |=> host_rvalid); // R7
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && !host_we) |=> !host_rvalid); // R7
  AST_SCAN_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> scan_valid); // R8
  AST_NO_SPURIOUS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> !scan_valid); // R8
  AST_COLOR_VIEW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && host_rvalid && $past(host_view) == 2'b01) |-> host_rdata[31:24] == 8'h00); // R3
  AST_FULL_VIEW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && host_rvalid && $past(host_view) == 2'b10) |-> host_rdata[31:26] == 6'h00); // R2
  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && host_rvalid && $past(host_view) == 2'b11) |-> host_rdata == 32'h0); // R6
endmodule

bind pixel_aperture_mem pixap_checker u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .host_view(host_addr[PIX_AW+1:PIX_AW]), .host_rdata(host_rdata),
  .host_rvalid(host_rvalid), .scan_en(scan_en), .scan_valid(scan_valid)
);

// File: tb/sim_pixel_aperture_mem.sv
`timescale 1ns/1ps
module sim_pixel_aperture_mem;
  localparam int PIX_AW = 6;
  localparam int NPIX   = 1 << PIX_AW;
  localparam int NQ     = NPIX / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [PIX_AW+1:0] host_addr = '0;
  logic [3:0] host_be = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic host_rvalid;
  logic scan_en = 1'b0;
  logic [PIX_AW-1:0] scan_addr = '0;
  logic scan_valid;
  logic [23:0] scan_color;
  logic [1:0] scan_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [25:0] ref_m [NPIX];

  always #5 clk = ~clk;

  pixel_aperture_mem #(.PIX_AW(PIX_AW)) u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .scan_en(scan_en),
    .scan_addr(scan_addr), .scan_valid(scan_valid), .scan_color(scan_color),
    .scan_mode(scan_mode)
  );

  function automatic logic [31:0] ref_read(logic [1:0] v, int off);
    int b;
    b = (off % NQ) * 4;
    case (v)
      2'b00:   return {ref_m[b+3][7:0], ref_m[b+2][7:0], ref_m[b+1][7:0], ref_m[b][7:0]};
      2'b01:   return {8'h00, ref_m[off][23:0]};
      2'b10:   return {6'h00, ref_m[off]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic ref_write(logic [1:0] v, int off, logic [3:0] be, logic [31:0] wd);
    int b;
    b = (off % NQ) * 4;
    if (v == 2'b00) begin
      for (int k = 0; k < 4; k++)
        if (be[k]) ref_m[b+k][7:0] = wd[8*k +: 8];
    end else if (v == 2'b01 || v == 2'b10) begin
      for (int k = 0; k < 3; k++)
        if (be[k]) ref_m[off][8*k +: 8] = wd[8*k +: 8];
      if (v == 2'b10 && be[3]) ref_m[off][25:24] = wd[25:24];
    end
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit req, bit we, logic [1:0] v, int off,
                      logic [3:0] be, logic [31:0] wd, bit sen, int sad);
    logic exp_rv, exp_sv;
    logic [31:0] exp_rd;
    logic [25:0] exp_sw;
    host_req = req; host_we = we; host_addr = {v, PIX_AW'(off)};
    host_be = be; host_wdata = wd; scan_en = sen; scan_addr = PIX_AW'(sad);
    exp_rv = req && !we;
    exp_rd = exp_rv ? ref_read(v, off % NPIX) : 32'h0;
    exp_sv = sen;
    exp_sw = sen ? ref_m[sad % NPIX] : 26'h0;
    if (req && we) ref_write(v, off % NPIX, be, wd);
    @(posedge clk); #1;
    chk(tag, "host_rvalid", 32'(host_rvalid), 32'(exp_rv));
    if (exp_rv) chk(tag, "host_rdata", host_rdata, exp_rd);
    chk(tag, "scan_valid", 32'(scan_valid), 32'(exp_sv));
    if (exp_sv) chk(tag, "scan_pixel", 32'({scan_mode, scan_color}), 32'(exp_sw));
  endtask

  task automatic hwr(string tag, logic [1:0] v, int off, logic [3:0] be, logic [31:0] wd);
    step(tag, 1'b1, 1'b1, v, off, be, wd, 1'b0, 0);
  endtask

  task automatic hrd(string tag, logic [1:0] v, int off);
    step(tag, 1'b1, 1'b0, v, off, 4'h0, 32'h0, 1'b0, 0);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; scan_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "host_rvalid in reset", 32'(host_rvalid), 32'h0);
    chk("R9", "scan_valid in reset", 32'(scan_valid), 32'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    apply_reset();
    step("R9", 1'b0, 1'b0, 2'b00, 0, 4'h0, 32'h0, 1'b0, 0);

    // Clear through the full view, with junk in bits 31:26 (R2).
    for (int i = 0; i < NPIX; i++)
      hwr("R2", 2'b10, i, 4'hF, {6'h2A, 2'(i), 24'(i * 32'h010203) ^ 24'h00A5A5});
    for (int i = 0; i < NPIX; i++) hrd("R2", 2'b10, i);

    // Colour view: lane 3 ignored, high byte reads zero.
    hwr("R3", 2'b01, 5, 4'hF, 32'hFF123456);
    hrd("R3", 2'b01, 5);
    hrd("R3", 2'b10, 5);

    // Partial byte enables in each view.
    hwr("R5", 2'b01, 6, 4'b0010, 32'hDEADBEEF);
    hrd("R5", 2'b10, 6);
    hwr("R5", 2'b10, 7, 4'b1000, 32'h03FFFFFF);
    hrd("R5", 2'b10, 7);
    hwr("R5", 2'b00, 4, 4'b0101, 32'hCAFEF00D);
    hrd("R5", 2'b00, 4);

    // Index view packing: four pixels, only low bytes.
    hwr("R4", 2'b00, 3, 4'hF, 32'h44332211);
    hrd("R4", 2'b00, 3);
    for (int i = 12; i < 16; i++) hrd("R4", 2'b10, i);

    // Undecoded high offset bits of the index view alias.
    hwr("R10", 2'b00, 3 + NQ, 4'hF, 32'h99887766);
    hrd("R10", 2'b00, 3);
    hrd("R10", 2'b00, 3 + 2 * NQ);

    // Unmapped window.
    hwr("R6", 2'b11, 9, 4'hF, 32'hFFFFFFFF);
    hrd("R6", 2'b11, 9);
    hrd("R6", 2'b10, 9);

    // One pixel seen through all three windows.
    hwr("R1", 2'b10, 20, 4'hF, 32'h01ABCDEF);
    hrd("R1", 2'b00, 5);
    hrd("R1", 2'b01, 20);
    hrd("R1", 2'b10, 20);

    // Strobe timing around reads, writes and idle cycles.
    hrd("R7", 2'b10, 1);
    hwr("R7", 2'b10, 1, 4'h1, 32'h0);
    step("R7", 1'b0, 1'b0, 2'b00, 0, 4'h0, 32'h0, 1'b0, 0);

    // Scan-out, including a same-pixel collision with a host write.
    for (int i = 0; i < 8; i++)
      step("R8", 1'b0, 1'b0, 2'b00, 0, 4'h0, 32'h0, 1'b1, i * 7);
    step("R8", 1'b1, 1'b1, 2'b10, 10, 4'hF, 32'h03112233, 1'b1, 10);
    step("R8", 1'b0, 1'b0, 2'b00, 0, 4'h0, 32'h0, 1'b1, 10);
    step("R8", 1'b1, 1'b0, 2'b10, 10, 4'h0, 32'h0, 1'b1, 11);

    // Storage survives reset.
    hwr("R9", 2'b10, 30, 4'hF, 32'h02FEDCBA);
    apply_reset();
    hrd("R9", 2'b10, 30);
    hrd("R9", 2'b01, 31);

    // Random mixed traffic over every window code.
    for (int n = 0; n < 4000; n++)
      step("R1", 1'($urandom), 1'($urandom), 2'($urandom), int'($urandom % NPIX),
           4'($urandom), $urandom, 1'($urandom), int'($urandom % NPIX));
    step("R7", 1'b0, 1'b0, 2'b00, 0, 4'h0, 32'h0, 1'b0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule